// File: doc/BRIEF.md
# Segment Descriptor Translation Unit

This block holds one segment register and turns offsets into 32-bit linear addresses. In protected mode, writing a 16-bit selector starts a single 64-bit read of an 8-byte descriptor from either the global or the local descriptor table. The block gathers the base and limit fragments that are spread across that descriptor, scales the limit when the granularity flag is set, and keeps the result in a cached descriptor register. After that, every translation request uses only the cached copy. Each request carries an offset and an intent (read, write or execute). The reply is either a linear address or a fault code, and no memory access is made.

In real mode a selector write does not touch memory. The address is the selector shifted left by four plus the offset, and no checks are applied. While a descriptor fetch is outstanding the block drops `ready`. Selector writes and translation requests presented during that window are not accepted. The requester holds its request until `ready` returns.

Top module: `seg_xlate_unit`

## Requirements
- R1: With `protMode` low, a selector write makes no memory request and keeps `ready` high. A translation then returns `(selector << 4) + offset` (32 bits, wrapping) with fault code 0 for any intent.
- R2: With `protMode` high, a selector write raises `memRdValid` with `memRdAddr` = table base + (selector[15:3] × 8). Selector bit 2 picks the table: 0 selects `gdtBase` and 1 selects `ldtBase`. The address stays stable until the handshake.
- R3: From the cycle after a protected selector write until the cycle after `memRdValid && memRdReady`, `ready` is low. Selector writes and translation requests in that window are ignored. The cycle after the handshake, `loadDone` pulses and `ready` returns high.
- R4: The cached base is built from descriptor bits 63:56 (base 31:24), 39:32 (base 23:16) and 31:16 (base 15:0). A granted protected translation returns base + offset.
- R5: The raw 20-bit limit is descriptor bits 51:48 over bits 15:0, and the granularity flag is bit 55. With the flag clear the byte limit is the raw limit. With the flag set it is (limit << 12) | 0xFFF.
- R6: A protected request whose offset exceeds the byte limit gets fault code 1 (limit) and address 0.
- R7: Descriptor bit 43 set marks a code segment and bit 41 is the read/write permission bit. Code: write faults, and read faults unless bit 41 is set. Data: execute faults, and write faults unless bit 41 is set. A type fault gives code 2 and address 0, and it takes priority over a limit fault.
- R8: A fetched descriptor with bit 47 (present) clear gives `loadFault` together with `loadDone`. The previous cached descriptor and `selOut` are kept.
- R9: A request accepted on a clock edge while `ready` is high produces `outValid` for exactly one cycle after that edge. Translations never start a memory request.
- R10: After reset `ready` is 1, `memRdValid`, `outValid` and `loadDone` are 0, and `selOut` is 0. The cached descriptor is base 0, byte limit 0xFFFF, data, writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| protMode | input | 1 | 1 = protected-mode translation, 0 = real mode |
| gdtBase | input | 32 | Global table base address |
| ldtBase | input | 32 | Local table base address |
| selWrEn | input | 1 | Selector write strobe |
| selIn | input | 16 | Selector value to load |
| selOut | output | 16 | Currently committed selector |
| ready | output | 1 | High when no descriptor fetch is pending |
| loadDone | output | 1 | One-cycle pulse when a fetch completes |
| loadFault | output | 1 | With loadDone: descriptor was not present |
| memRdValid | output | 1 | Descriptor read request |
| memRdAddr | output | 32 | Descriptor byte address |
| memRdReady | input | 1 | Memory accepts the read, data valid this cycle |
| memRdData | input | 64 | Descriptor contents |
| xlValid | input | 1 | Translation request |
| xlOffset | input | 32 | Offset within the segment |
| xlKind | input | 2 | Intent: 0 read, 1 write, 2 execute |
| outValid | output | 1 | Translation result valid |
| outAddr | output | 32 | Linear address (0 on fault) |
| outFault | output | 2 | 0 none, 1 limit, 2 type |

## Verification
The tests use four kinds of descriptor: a flat code segment with page granularity, a byte-granular data segment at an odd base, a page-granular segment in the local table, and segments that are execute-only or read-only. Between them they separate correct field reassembly from a swapped or shifted base, byte scaling from page scaling, and global from local table selection. Offsets sit exactly at the byte limit and one byte past it, and each intent is applied to each segment type, so off-by-one limit compares and wrong type rules both show up. A not-present load, and a selector write made while a fetch is pending, show whether the old cache and selector survive. Real-mode requests paired with a fetch counter confirm that the lookup is bypassed.

// File: rtl/seg_xlate_pkg.sv
`timescale 1ns/1ps
package seg_xlate_pkg;

  localparam int LIN_W  = 32;
  localparam int DESC_W = 64;

  typedef enum logic [1:0] {
    XL_READ  = 2'd0,
    XL_WRITE = 2'd1,
    XL_EXEC  = 2'd2
  } xlKindE;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_LIMIT = 2'd1,
    FLT_TYPE  = 2'd2
  } faultE;

  // strobes from control to datapath
  typedef struct packed {
    logic latchSel;     // protected selector write accepted
    logic realSel;      // real-mode selector write accepted
    logic fetchActive;  // descriptor read outstanding
    logic commitDesc;   // handshake with present descriptor
    logic rejectDesc;   // handshake with absent descriptor
    logic acceptXl;     // translation request taken
  } ctrlStrbT;

  typedef struct packed {
    logic [LIN_W-1:0] base;
    logic [LIN_W-1:0] byteLimit;
    logic             isCode;
    logic             rwOk;
  } descCacheT;

endpackage

// File: rtl/seg_xlate_ctrl.sv
`timescale 1ns/1ps
module seg_xlate_ctrl
  import seg_xlate_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     protMode,
  input  logic     selWrEn,
  input  logic     xlValid,
  input  logic     memRdReady,
  input  logic     descPresent,
  output logic     ready,
  output logic     memRdValid,
  output logic     loadDone,
  output logic     loadFault,
  output ctrlStrbT strb
);

  typedef enum logic {ST_IDLE, ST_FETCH} stateE;
  stateE state;
  logic  isIdle;
  logic  handshake;

  assign isIdle    = (state == ST_IDLE);
  assign handshake = (state == ST_FETCH) && memRdReady;

  always_comb begin
    strb             = '0;
    strb.latchSel    = isIdle && selWrEn && protMode;
    strb.realSel     = isIdle && selWrEn && !protMode;
    strb.fetchActive = (state == ST_FETCH);
    strb.commitDesc  = handshake && descPresent;
    strb.rejectDesc  = handshake && !descPresent;
    strb.acceptXl    = isIdle && xlValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      loadDone  <= 1'b0;
      loadFault <= 1'b0;
    end else begin
      loadDone  <= handshake;
      loadFault <= handshake && !descPresent;
      case (state)
        ST_IDLE:  if (strb.latchSel) state <= ST_FETCH;
        ST_FETCH: if (handshake)     state <= ST_IDLE;
        default:                     state <= ST_IDLE;
      endcase
    end
  end

  assign ready      = isIdle;
  assign memRdValid = (state == ST_FETCH);

  // R1: a real-mode selector write never stalls the unit
  p_real_load_no_stall_r1: assert property (@(posedge clk) disable iff (!rstN)
    (selWrEn && !protMode && ready) |=> ready);

  // R3: completion pulse only follows a memory handshake
  p_done_after_handshake_r3: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |-> $past(memRdValid && memRdReady));

  // R3: ready comes back right after the handshake
  p_ready_after_done_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memRdValid && memRdReady) |=> (ready && !memRdValid));

endmodule

// File: rtl/seg_xlate_dp.sv
`timescale 1ns/1ps
module seg_xlate_dp
  import seg_xlate_pkg::*;
#(
  parameter int SEL_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               protMode,
  input  ctrlStrbT           strb,
  input  logic [LIN_W-1:0]   gdtBase,
  input  logic [LIN_W-1:0]   ldtBase,
  input  logic [SEL_W-1:0]   selIn,
  input  logic               memRdReady,
  input  logic [DESC_W-1:0]  memRdData,
  input  logic [LIN_W-1:0]   xlOffset,
  input  logic [1:0]         xlKind,
  output logic [SEL_W-1:0]   selOut,
  output logic [LIN_W-1:0]   memRdAddr,
  output logic               descPresent,
  output logic               outValid,
  output logic [LIN_W-1:0]   outAddr,
  output logic [1:0]         outFault
);

  localparam int TI_BIT    = 2;
  localparam int IDX_LSB   = 3;
  localparam int IDX_W     = SEL_W - IDX_LSB;
  localparam int REAL_SH   = 4;
  localparam int REAL_PAD  = LIN_W - SEL_W - REAL_SH;
  localparam int IDX_PAD   = LIN_W - IDX_W - IDX_LSB;
  localparam int RAW_LIM_W = 20;
  localparam int PAGE_SH   = 12;

  logic [SEL_W-1:0] pendSel;
  logic [SEL_W-1:0] curSel;
  descCacheT        cache;
  descCacheT        fetched;

  // descriptor address: chosen table base plus index times eight
  logic [LIN_W-1:0] tblBase;
  assign tblBase   = pendSel[TI_BIT] ? ldtBase : gdtBase;
  assign memRdAddr = tblBase + {{IDX_PAD{1'b0}}, pendSel[SEL_W-1:IDX_LSB], {IDX_LSB{1'b0}}};

  // reassemble scattered fields
  logic [RAW_LIM_W-1:0] rawLimit;
  logic                 granPage;
  always_comb begin
    rawLimit          = {memRdData[51:48], memRdData[15:0]};
    granPage          = memRdData[55];
    fetched.base      = {memRdData[63:56], memRdData[39:32], memRdData[31:16]};
    fetched.byteLimit = granPage ? {rawLimit, {PAGE_SH{1'b1}}}
                                 : {{(LIN_W-RAW_LIM_W){1'b0}}, rawLimit};
    fetched.isCode    = memRdData[43];
    fetched.rwOk      = memRdData[41];
  end
  assign descPresent = memRdData[47];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendSel         <= '0;
      curSel          <= '0;
      cache.base      <= '0;
      cache.byteLimit <= {{(LIN_W-16){1'b0}}, 16'hFFFF};
      cache.isCode    <= 1'b0;
      cache.rwOk      <= 1'b1;
    end else begin
      if (strb.latchSel)   pendSel <= selIn;
      if (strb.realSel)    curSel  <= selIn;
      if (strb.commitDesc) begin
        curSel <= pendSel;
        cache  <= fetched;
      end
    end
  end
  assign selOut = curSel;

  // translation
  logic [LIN_W-1:0] realAddr;
  logic [LIN_W-1:0] protAddr;
  logic             typeBad;
  logic             limitBad;

  assign realAddr = {{REAL_PAD{1'b0}}, curSel, {REAL_SH{1'b0}}} + xlOffset;
  assign protAddr = cache.base + xlOffset;
  assign limitBad = xlOffset > cache.byteLimit;

  always_comb begin
    if (cache.isCode)
      typeBad = (xlKind == XL_WRITE) || ((xlKind == XL_READ) && !cache.rwOk);
    else
      typeBad = (xlKind == XL_EXEC) || ((xlKind == XL_WRITE) && !cache.rwOk);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outAddr  <= '0;
      outFault <= FLT_NONE;
    end else begin
      outValid <= strb.acceptXl;
      if (strb.acceptXl) begin
        if (!protMode) begin
          outAddr  <= realAddr;
          outFault <= FLT_NONE;
        end else if (typeBad) begin
          outAddr  <= '0;
          outFault <= FLT_TYPE;
        end else if (limitBad) begin
          outAddr  <= '0;
          outFault <= FLT_LIMIT;
        end else begin
          outAddr  <= protAddr;
          outFault <= FLT_NONE;
        end
      end
    end
  end

  // R2: request address held steady until accepted
  p_fetch_addr_stable_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fetchActive && !memRdReady) |=> $stable(memRdAddr));

  // R8: absent descriptor leaves selector and cache untouched
  p_reject_keeps_state_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.rejectDesc |=> ($stable(curSel) && $stable(cache)));

  // R6: any faulted result carries no address
  p_fault_no_addr_r6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && (outFault != FLT_NONE)) |-> (outAddr == '0));

  // R9: results appear only for accepted requests
  p_result_needs_accept_r9: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(strb.acceptXl));

endmodule

// File: rtl/seg_xlate_unit.sv
`timescale 1ns/1ps
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter int SEL_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              protMode,
  input  logic [31:0]       gdtBase,
  input  logic [31:0]       ldtBase,
  input  logic              selWrEn,
  input  logic [SEL_W-1:0]  selIn,
  output logic [SEL_W-1:0]  selOut,
  output logic              ready,
  output logic              loadDone,
  output logic              loadFault,
  output logic              memRdValid,
  output logic [31:0]       memRdAddr,
  input  logic              memRdReady,
  input  logic [63:0]       memRdData,
  input  logic              xlValid,
  input  logic [31:0]       xlOffset,
  input  logic [1:0]        xlKind,
  output logic              outValid,
  output logic [31:0]       outAddr,
  output logic [1:0]        outFault
);

  ctrlStrbT strb;
  logic     descPresent;

  seg_xlate_ctrl i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .protMode    (protMode),
    .selWrEn     (selWrEn),
    .xlValid     (xlValid),
    .memRdReady  (memRdReady),
    .descPresent (descPresent),
    .ready       (ready),
    .memRdValid  (memRdValid),
    .loadDone    (loadDone),
    .loadFault   (loadFault),
    .strb        (strb)
  );

  seg_xlate_dp #(.SEL_W(SEL_W)) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .protMode    (protMode),
    .strb        (strb),
    .gdtBase     (gdtBase),
    .ldtBase     (ldtBase),
    .selIn       (selIn),
    .memRdReady  (memRdReady),
    .memRdData   (memRdData),
    .xlOffset    (xlOffset),
    .xlKind      (xlKind),
    .selOut      (selOut),
    .memRdAddr   (memRdAddr),
    .descPresent (descPresent),
    .outValid    (outValid),
    .outAddr     (outAddr),
    .outFault    (outFault)
  );

endmodule

// File: tb/test_seg_xlate_unit.sv
`timescale 1ns/1ps
module test_seg_xlate_unit;

  logic        clk = 1'b0;
  logic        rstN;
  logic        protMode;
  logic [31:0] gdtBase, ldtBase;
  logic        selWrEn;
  logic [15:0] selIn, selOut;
  logic        ready, loadDone, loadFault;
  logic        memRdValid, memRdReady;
  logic [31:0] memRdAddr;
  logic [63:0] memRdData;
  logic        xlValid;
  logic [31:0] xlOffset;
  logic [1:0]  xlKind;
  logic        outValid;
  logic [31:0] outAddr;
  logic [1:0]  outFault;

  int checks = 0;
  int fails  = 0;
  int fetchCount = 0;
  int waitCnt = 0;

  localparam logic [1:0] K_RD = 2'd0, K_WR = 2'd1, K_EX = 2'd2;
  localparam logic [1:0] F_NO = 2'd0, F_LIM = 2'd1, F_TYP = 2'd2;

  always #2.5 clk = ~clk;

  seg_xlate_unit i_seg_xlate_unit (
    .clk(clk), .rstN(rstN), .protMode(protMode), .gdtBase(gdtBase), .ldtBase(ldtBase),
    .selWrEn(selWrEn), .selIn(selIn), .selOut(selOut), .ready(ready),
    .loadDone(loadDone), .loadFault(loadFault), .memRdValid(memRdValid),
    .memRdAddr(memRdAddr), .memRdReady(memRdReady), .memRdData(memRdData),
    .xlValid(xlValid), .xlOffset(xlOffset), .xlKind(xlKind),
    .outValid(outValid), .outAddr(outAddr), .outFault(outFault)
  );

  function automatic logic [63:0] mkDesc(input logic [31:0] b, input logic [19:0] lim,
                                         input logic g, input logic [7:0] acc);
    return {b[31:24], g, 1'b1, 2'b00, lim[19:16], acc, b[23:16], b[15:0], lim[15:0]};
  endfunction

  function automatic logic [63:0] lookup(input logic [31:0] a);
    case (a)
      32'h0001_0008: return mkDesc(32'h0000_0000, 20'hFFFFF, 1'b1, 8'h9A);
      32'h0001_0010: return mkDesc(32'h1234_5000, 20'h00FFF, 1'b0, 8'h92);
      32'h0002_0008: return mkDesc(32'h8000_0000, 20'h00002, 1'b1, 8'h92);
      32'h0001_0018: return mkDesc(32'h5555_0000, 20'hFFFFF, 1'b1, 8'h12);
      32'h0001_0020: return mkDesc(32'h0000_4000, 20'h000FF, 1'b0, 8'h98);
      32'h0001_0028: return mkDesc(32'h0000_0100, 20'h000FF, 1'b0, 8'h90);
      default:       return 64'h0;
    endcase
  endfunction

  // memory model: answers two cycles after a request appears
  always @(negedge clk) begin
    if (memRdReady) begin
      memRdReady <= 1'b0;
      waitCnt    <= 0;
    end else if (memRdValid) begin
      if (waitCnt == 2) begin
        memRdReady <= 1'b1;
        memRdData  <= lookup(memRdAddr);
      end else begin
        waitCnt <= waitCnt + 1;
      end
    end
  end

  always @(posedge clk) if (rstN && memRdValid && memRdReady) fetchCount++;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // selector load; protected loads wait for completion
  task automatic loadSel(input logic [15:0] sel, input logic [31:0] expAddr, input bit expFault);
    @(negedge clk);
    selWrEn = 1'b1; selIn = sel;
    @(negedge clk);
    selWrEn = 1'b0;
    if (protMode) begin
      check(memRdValid === 1'b1, "R2 request raised", {31'b0, memRdValid}, 32'h1);
      check(memRdAddr === expAddr, "R2 descriptor address", memRdAddr, expAddr);
      check(ready === 1'b0, "R3 ready low while fetching", {31'b0, ready}, 32'h0);
      for (int i = 0; i < 50 && loadDone !== 1'b1; i++) @(negedge clk);
      check(loadDone === 1'b1, "R3 load completes", {31'b0, loadDone}, 32'h1);
      check(ready === 1'b1, "R3 ready restored", {31'b0, ready}, 32'h1);
      check(loadFault === expFault, "R8 load fault flag", {31'b0, loadFault}, {31'b0, expFault});
    end else begin
      check(memRdValid === 1'b0 && ready === 1'b1, "R1 no fetch in real mode",
            {30'b0, memRdValid, ready}, 32'h1);
    end
  endtask

  task automatic xlate(input logic [31:0] off, input logic [1:0] kind,
                       input logic [1:0] expFlt, input logic [31:0] expAddr, input string req);
    @(negedge clk);
    xlValid = 1'b1; xlOffset = off; xlKind = kind;
    @(negedge clk);
    xlValid = 1'b0;
    check(outValid === 1'b1, req, {31'b0, outValid}, 32'h1);
    check(outFault === expFlt, req, {30'b0, outFault}, {30'b0, expFlt});
    check(outAddr === expAddr, req, outAddr, expAddr);
    @(negedge clk);
    check(outValid === 1'b0, "R9 single-cycle result", {31'b0, outValid}, 32'h0);
  endtask

  task automatic testReset();
    check(ready === 1'b1, "R10 ready after reset", {31'b0, ready}, 32'h1);
    check(memRdValid === 1'b0 && outValid === 1'b0 && loadDone === 1'b0, "R10 idle outputs",
          {29'b0, memRdValid, outValid, loadDone}, 32'h0);
    check(selOut === 16'h0, "R10 selector cleared", {16'b0, selOut}, 32'h0);
    protMode = 1'b1;
    xlate(32'h0000_FFFF, K_WR, F_NO, 32'h0000_FFFF, "R10 reset cache limit edge");
    xlate(32'h0001_0000, K_RD, F_LIM, 32'h0, "R10 reset cache past limit");
  endtask

  task automatic testRealMode();
    int f0;
    protMode = 1'b0;
    f0 = fetchCount;
    loadSel(16'h1234, 32'h0, 1'b0);
    xlate(32'h0000_0005, K_EX, F_NO, 32'h0001_2345, "R1 real address");
    xlate(32'h0000_FFFF, K_WR, F_NO, 32'h0002_233F, "R1 real address high offset");
    check(fetchCount == f0, "R1 no memory access", fetchCount, f0);
    check(selOut === 16'h1234, "R1 selector held", {16'b0, selOut}, 32'h1234);
  endtask

  task automatic testDataByteGran();
    int f0;
    protMode = 1'b1;
    loadSel(16'h0010, 32'h0001_0010, 1'b0);
    f0 = fetchCount;
    xlate(32'h0000_0FFF, K_RD, F_NO, 32'h1234_5FFF, "R4 base plus offset at R5 byte limit");
    xlate(32'h0000_1000, K_RD, F_LIM, 32'h0, "R6 one past byte limit");
    xlate(32'h0000_0010, K_WR, F_NO, 32'h1234_5010, "R7 write to writable data");
    xlate(32'h0000_0010, K_EX, F_TYP, 32'h0, "R7 execute from data");
    check(fetchCount == f0, "R9 translations make no fetch", fetchCount, f0);
  endtask

  task automatic testFlatCode();
    loadSel(16'h0008, 32'h0001_0008, 1'b0);
    xlate(32'hFFFF_FFFF, K_EX, F_NO, 32'hFFFF_FFFF, "R5 page-granular full space");
    xlate(32'h0000_1234, K_RD, F_NO, 32'h0000_1234, "R7 read of readable code");
    xlate(32'h0000_1234, K_WR, F_TYP, 32'h0, "R7 write to code");
  endtask

  task automatic testLocalTable();
    loadSel(16'h000C, 32'h0002_0008, 1'b0);
    xlate(32'h0000_2FFF, K_RD, F_NO, 32'h8000_2FFF, "R5 scaled limit edge");
    xlate(32'h0000_3000, K_WR, F_LIM, 32'h0, "R6 past scaled limit");
  endtask

  task automatic testNotPresent();
    loadSel(16'h0018, 32'h0001_0018, 1'b1);
    check(selOut === 16'h000C, "R8 selector kept", {16'b0, selOut}, 32'h000C);
    xlate(32'h0000_2FFF, K_RD, F_NO, 32'h8000_2FFF, "R8 old cache kept");
  endtask

  task automatic testPendingIgnored();
    @(negedge clk);
    selWrEn = 1'b1; selIn = 16'h0020;
    @(negedge clk);
    selWrEn = 1'b1; selIn = 16'h0028;
    xlValid = 1'b1; xlOffset = 32'h0; xlKind = K_RD;
    @(negedge clk);
    selWrEn = 1'b0; xlValid = 1'b0;
    check(outValid === 1'b0, "R3 request ignored while busy", {31'b0, outValid}, 32'h0);
    check(memRdAddr === 32'h0001_0020, "R3 selector write ignored while busy", memRdAddr, 32'h0001_0020);
    for (int i = 0; i < 50 && loadDone !== 1'b1; i++) @(negedge clk);
    check(loadDone === 1'b1 && loadFault === 1'b0, "R3 pending load done",
          {30'b0, loadDone, loadFault}, 32'h2);
    check(selOut === 16'h0020, "R3 first selector committed", {16'b0, selOut}, 32'h0020);
    xlate(32'h0000_00FF, K_EX, F_NO, 32'h0000_40FF, "R7 execute-only code");
    xlate(32'h0000_0100, K_EX, F_LIM, 32'h0, "R6 execute past limit");
    xlate(32'h0000_0000, K_RD, F_TYP, 32'h0, "R7 read of execute-only code");
  endtask

  task automatic testReadOnlyData();
    loadSel(16'h0028, 32'h0001_0028, 1'b0);
    xlate(32'h0000_0080, K_RD, F_NO, 32'h0000_0180, "R7 read of read-only data");
    xlate(32'h0000_0080, K_WR, F_TYP, 32'h0, "R7 write to read-only data");
    xlate(32'h0000_1000, K_EX, F_TYP, 32'h0, "R7 type fault wins over limit");
  endtask

  initial begin
    #(5 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    rstN = 1'b0; protMode = 1'b0; gdtBase = 32'h0001_0000; ldtBase = 32'h0002_0000;
    selWrEn = 1'b0; selIn = '0; xlValid = 1'b0; xlOffset = '0; xlKind = K_RD;
    memRdReady = 1'b0; memRdData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRealMode();
    testDataByteGran();
    testFlatCode();
    testLocalTable();
    testNotPresent();
    testPendingIgnored();
    testReadOnlyData();
    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule